// File: doc/BRIEF.md
# Banked Row-Buffer Data Cache

This block is a processor data cache whose lines are the wide row buffers of a set of independent memory banks. With the default parameters the memory is split into sixteen banks. Each bank keeps two 512-byte buffers, and those two buffers are the two ways of that bank's set. The whole cache is therefore 2-way set-associative with 32 lines of 4096 bits, 16 KB in total. The bank index is taken from the address bits just above the line offset, so consecutive lines fall in different banks.

The processor side is a 64-bit load/store port with a valid/ready handshake. A hit is accepted in the cycle it is presented, and read data returns one cycle later. On a miss, ready stays low and the block sends one request to the array of the addressed bank. That request asks for the missing row. If the chosen victim line is dirty, the same request also carries the victim line back to the array. The returned 4096-bit row is installed in a single transfer, and the stalled request then completes as a hit. After every fill, a bank stays unavailable to the array for a recovery interval. Hits and the other banks are not held up by it.

Top module: `colbuf_dcache`

## Requirements
- R1: After reset, resp_valid and mem_req are low and no line is valid, so the first access to any address is a miss that produces an array request.
- R2: The address decodes as word select addr[8:3], bank addr[12:9] and tag addr[31:13]. A read returns the 64-bit word at that word select. The array request carries the missing bank on mem_bank and its tag on mem_rd_row.
- R3: A miss produces exactly one array request. mem_req is high for one cycle, in the cycle after the miss is seen. req_ready stays low until the row returns on mem_rvalid.
- R4: A fill installs the entire 4096-bit mem_rdata row at once. Every word of that line then hits, with no further array request.
- R5: For a hit, req_ready is high in the same cycle as req_valid. A read hit gives resp_valid with resp_rdata one cycle after acceptance. A write gives no response.
- R6: Each bank holds lines of two different tags at the same time, and both hit.
- R7: The replacement way is an invalid way if one exists, way 0 before way 1. Otherwise it is the least recently used of the bank's two ways. Recency is updated on every accepted hit and on every fill.
- R8: A write replaces only the bytes whose req_be bit is set (bit i covers data bits 8i+7 to 8i) and keeps the others. A write with req_be all zero changes nothing. A write miss first fills the line, then writes it.
- R9: When the victim is dirty, its request has mem_wb_en high, mem_wb_row equal to the victim's tag and mem_wdata equal to the victim line including all writes. A clean or invalid victim gives mem_wb_en low.
- R10: After a fill, that bank issues no new array request for PRECHARGE cycles (default 3). With a miss already waiting, the next request to that bank appears on mem_req in the cycle after those PRECHARGE cycles. A miss to a different bank is issued without that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Request accepted this cycle; low during a miss |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | 64 | Load data |
| mem_req | output | 1 | One-cycle array request |
| mem_bank | output | 4 | Bank of the request |
| mem_rd_row | output | 19 | Tag of the row to read |
| mem_wb_en | output | 1 | Request also writes back a dirty line |
| mem_wb_row | output | 19 | Tag of the written-back row |
| mem_wdata | output | 4096 | Written-back line |
| mem_rvalid | input | 1 | Requested row is on mem_rdata |
| mem_rdata | input | 4096 | Returned row |

## Verification
The hardest case to reach is a dirty eviction. It needs a store that hits a line, a second line filled into the other way of the same bank, and a hit on that second line so that the stored-to line becomes least recently used. Only then does a third tag in that bank force the write-back. The stimulus builds that sequence in one bank. It checks the request fields and the written-back word, then reloads the evicted address so that the stored bytes come back through the array.

Precharge timing is reached by sending a second miss to the same bank immediately after a fill. The bench measures the exact gap between fill and request and compares it with the gap for a miss to a different bank.

// File: rtl/colbuf_pkg.sv
`timescale 1ns/1ps
package colbuf_pkg;
    localparam int CB_ADDR_W     = 32;
    localparam int CB_DATA_W     = 64;
    localparam int CB_LINE_BYTES = 512;
    localparam int CB_BANKS      = 16;
    localparam int CB_PRECHARGE  = 3;

    typedef enum logic [0:0] {
        CB_IDLE = 1'b0,
        CB_FILL = 1'b1
    } cb_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } cb_meta_t;

    // next LRU pointer after touching a way: the other way becomes the victim
    function automatic logic cb_lru_after(input logic touched_way);
        return ~touched_way;
    endfunction
endpackage

// File: rtl/colbuf_bank.sv
`timescale 1ns/1ps
module colbuf_bank
    import colbuf_pkg::*;
#(
    parameter int TAG_W     = 19,
    parameter int LINE_W    = 4096,
    parameter int DATA_W    = 64,
    parameter int WIDX_W    = 6,
    parameter int PRECHARGE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WIDX_W-1:0] lk_word,
    output logic              hit,
    output logic              hit_way,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic              touch_en,
    input  logic              arr_start,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    output logic              victim_way,
    output logic              victim_wb,
    output logic [TAG_W-1:0]  victim_tag,
    output logic [LINE_W-1:0] victim_line,
    output logic              busy
);
    localparam int NBYTES = DATA_W / 8;
    localparam int PRE_W  = $clog2(PRECHARGE + 1);

    logic [LINE_W-1:0] line_v [2];
    logic [TAG_W-1:0]  tag_v  [2];
    cb_meta_t          meta_v [2];
    logic [1:0]        way_hit;
    logic              lru_q;
    logic [PRE_W-1:0]  pre_cnt_q;
    logic              inflight_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] line_r;
        logic [TAG_W-1:0]  tag_r;
        cb_meta_t          meta_r;
        logic              is_fill;
        logic              is_write;

        assign is_fill  = fill_en && (fill_way == 1'(w));
        assign is_write = wr_en && hit && (hit_way == 1'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_r <= '0;
                tag_r  <= '0;
            end else if (is_fill) begin
                meta_r <= '{valid: 1'b1, dirty: 1'b0};
                tag_r  <= fill_tag;
            end else if (is_write) begin
                meta_r.dirty <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (is_fill) begin
                line_r <= fill_line;
            end else if (is_write) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (wr_be[b]) begin
                        line_r[int'(lk_word)*DATA_W + b*8 +: 8] <= wr_data[b*8 +: 8];
                    end
                end
            end
        end

        assign line_v[w]  = line_r;
        assign tag_v[w]   = tag_r;
        assign meta_v[w]  = meta_r;
        assign way_hit[w] = meta_r.valid && (tag_r == lk_tag);
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];
    assign rd_word = line_v[hit_way][int'(lk_word)*DATA_W +: DATA_W];

    always_comb begin
        if (!meta_v[0].valid)      victim_way = 1'b0;
        else if (!meta_v[1].valid) victim_way = 1'b1;
        else                       victim_way = lru_q;
    end

    assign victim_wb   = meta_v[victim_way].valid && meta_v[victim_way].dirty;
    assign victim_tag  = tag_v[victim_way];
    assign victim_line = line_v[victim_way];

    always_ff @(posedge clk) begin
        if (rst)                  lru_q <= 1'b0;
        else if (fill_en)         lru_q <= cb_lru_after(fill_way);
        else if (touch_en && hit) lru_q <= cb_lru_after(hit_way);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= 1'b0;
            pre_cnt_q  <= '0;
        end else if (arr_start) begin
            inflight_q <= 1'b1;
        end else if (fill_en) begin
            inflight_q <= 1'b0;
            pre_cnt_q  <= PRE_W'(PRECHARGE);
        end else if (pre_cnt_q != '0) begin
            pre_cnt_q  <= pre_cnt_q - 1'b1;
        end
    end

    assign busy = inflight_q || (pre_cnt_q != '0);

    // R6
    dual_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !(way_hit[0] && way_hit[1]));

    // R10
    recover_busy_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> busy);

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        arr_start |-> !busy);
endmodule

// File: rtl/colbuf_ctrl.sv
`timescale 1ns/1ps
module colbuf_ctrl
    import colbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic sel_hit,
    input  logic sel_busy,
    input  logic mem_rvalid,
    output logic req_ready,
    output logic start,
    output logic fill,
    output logic accept
);
    cb_state_e state_q;

    assign req_ready = (state_q == CB_IDLE) && sel_hit;
    assign accept    = req_valid && req_ready;
    assign start     = (state_q == CB_IDLE) && req_valid && !sel_hit && !sel_busy;
    assign fill      = (state_q == CB_FILL) && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst)        state_q <= CB_IDLE;
        else if (start) state_q <= CB_FILL;
        else if (fill)  state_q <= CB_IDLE;
    end

    // R3
    no_double_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
endmodule

// File: rtl/colbuf_dcache.sv
`timescale 1ns/1ps
module colbuf_dcache
    import colbuf_pkg::*;
#(
    parameter int ADDR_W     = CB_ADDR_W,
    parameter int DATA_W     = CB_DATA_W,
    parameter int LINE_BYTES = CB_LINE_BYTES,
    parameter int BANKS      = CB_BANKS,
    parameter int PRECHARGE  = CB_PRECHARGE
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    input  logic req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic mem_req,
    output logic [$clog2(BANKS)-1:0] mem_bank,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(BANKS)-1:0] mem_rd_row,
    output logic mem_wb_en,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(BANKS)-1:0] mem_wb_row,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    input  logic mem_rvalid,
    input  logic [LINE_BYTES*8-1:0] mem_rdata
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WIDX_W = OFF_W - BYTE_W;
    localparam int BANK_W = $clog2(BANKS);
    localparam int TAG_W  = ADDR_W - OFF_W - BANK_W;

    logic [BANK_W-1:0] req_bank;
    logic [WIDX_W-1:0] req_word;
    logic [TAG_W-1:0]  req_tag;
    logic              unused_lowbits;

    assign req_bank       = req_addr[OFF_W +: BANK_W];
    assign req_word       = req_addr[BYTE_W +: WIDX_W];
    assign req_tag        = req_addr[OFF_W + BANK_W +: TAG_W];
    assign unused_lowbits = ^req_addr[BYTE_W-1:0];

    logic [BANKS-1:0]  b_hit, b_hit_way, b_busy, b_vway, b_vwb;
    logic [DATA_W-1:0] b_rd_word [BANKS];
    logic [TAG_W-1:0]  b_vtag    [BANKS];
    logic [LINE_W-1:0] b_vline   [BANKS];

    logic sel_hit, sel_busy, start, fill, accept;

    assign sel_hit  = b_hit[req_bank];
    assign sel_busy = b_busy[req_bank];

    colbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .sel_hit    (sel_hit),
        .sel_busy   (sel_busy),
        .mem_rvalid (mem_rvalid),
        .req_ready  (req_ready),
        .start      (start),
        .fill       (fill),
        .accept     (accept)
    );

    logic [BANK_W-1:0] bank_q;
    logic [TAG_W-1:0]  rd_row_q, wb_row_q;
    logic              wb_en_q, way_q, mem_req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req_q <= 1'b0;
            bank_q    <= '0;
            rd_row_q  <= '0;
            wb_row_q  <= '0;
            wb_en_q   <= 1'b0;
            way_q     <= 1'b0;
        end else begin
            mem_req_q <= start;
            if (start) begin
                bank_q   <= req_bank;
                rd_row_q <= req_tag;
                wb_row_q <= b_vtag[req_bank];
                wb_en_q  <= b_vwb[req_bank];
                way_q    <= b_vway[req_bank];
            end
        end
    end

    assign mem_req    = mem_req_q;
    assign mem_bank   = bank_q;
    assign mem_rd_row = rd_row_q;
    assign mem_wb_en  = wb_en_q;
    assign mem_wb_row = wb_row_q;
    assign mem_wdata  = b_vline[bank_q];

    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            resp_valid_q <= accept && !req_we;
            if (accept && !req_we) resp_rdata_q <= b_rd_word[req_bank];
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_rdata_q;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic here;
        assign here = (req_bank == BANK_W'(b));

        colbuf_bank #(
            .TAG_W     (TAG_W),
            .LINE_W    (LINE_W),
            .DATA_W    (DATA_W),
            .WIDX_W    (WIDX_W),
            .PRECHARGE (PRECHARGE)
        ) u_bank (
            .clk         (clk),
            .rst         (rst),
            .lk_tag      (req_tag),
            .lk_word     (req_word),
            .hit         (b_hit[b]),
            .hit_way     (b_hit_way[b]),
            .rd_word     (b_rd_word[b]),
            .wr_en       (accept && req_we && here),
            .wr_data     (req_wdata),
            .wr_be       (req_be),
            .touch_en    (accept && here),
            .arr_start   (start && here),
            .fill_en     (fill && (bank_q == BANK_W'(b))),
            .fill_way    (way_q),
            .fill_tag    (rd_row_q),
            .fill_line   (mem_rdata),
            .victim_way  (b_vway[b]),
            .victim_wb   (b_vwb[b]),
            .victim_tag  (b_vtag[b]),
            .victim_line (b_vline[b]),
            .busy        (b_busy[b])
        );
    end

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R5
    resp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid && req_ready && !req_we));

    // R2
    req_bank_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_bank == $past(req_addr[OFF_W +: BANK_W])));

    // R9
    wb_row_differs_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_wb_en) |-> (mem_wb_row != mem_rd_row));
endmodule

// File: tb/colbuf_dcache_bench.sv
`timescale 1ns/1ps
module colbuf_dcache_bench;
    localparam int LAT    = 6;
    localparam int PRE    = 3;
    localparam int LINE_W = 4096;
    localparam int WORDS  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic req_ready, resp_valid, mem_req, mem_wb_en;
    logic [63:0] resp_rdata;
    logic [3:0]  mem_bank;
    logic [18:0] mem_rd_row, mem_wb_row;
    logic [LINE_W-1:0] mem_wdata;
    logic mem_rvalid = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    colbuf_dcache #(.PRECHARGE(PRE)) u_colbuf_dcache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_bank(mem_bank), .mem_rd_row(mem_rd_row),
        .mem_wb_en(mem_wb_en), .mem_wb_row(mem_wb_row), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input logic [18:0] tag, input logic [3:0] bank, input int w);
        return {13'h0, tag, 4'h0, bank, 8'hC3, 16'(w)};
    endfunction

    function automatic logic [31:0] mk(input int tag, input int bank, input int w);
        return {19'(tag), 4'(bank), 6'(w), 3'b000};
    endfunction

    // reference word model, keyed by word address
    logic [63:0] ref_mem [int unsigned];

    function automatic logic [63:0] exp_word(input logic [31:0] a);
        int unsigned k = int'(a >> 3);
        if (ref_mem.exists(k)) return ref_mem[k];
        return pat(a[31:13], a[12:9], int'(a[8:3]));
    endfunction

    // array model
    logic [LINE_W-1:0] store [int unsigned];

    function automatic logic [LINE_W-1:0] line_of(input logic [3:0] bank, input logic [18:0] row);
        logic [LINE_W-1:0] l;
        int unsigned k = int'({row, bank});
        if (store.exists(k)) return store[k];
        for (int w = 0; w < WORDS; w++) l[w*64 +: 64] = pat(row, bank, w);
        return l;
    endfunction

    int cyc = 0;
    int req_count = 0;
    int mem_cnt = 0;
    int fill_cyc [16];
    int last_fill_any = -100;
    int gap_same = 0, gap_any = 0;
    logic [3:0]  pend_bank = '0, last_bank = '0;
    logic [18:0] pend_row = '0, last_rd_row = '0, last_wb_row = '0;
    logic        last_wb_en = 1'b0;
    logic [LINE_W-1:0] last_wdata = '0;

    initial foreach (fill_cyc[i]) fill_cyc[i] = -100;

    always @(posedge clk) begin
        cyc++;
        if (mem_rvalid) begin
            fill_cyc[pend_bank] = cyc;
            last_fill_any = cyc;
        end
        mem_rvalid <= 1'b0;
        if (!rst && mem_req) begin
            req_count++;
            gap_same    = cyc - fill_cyc[mem_bank];
            gap_any     = cyc - last_fill_any;
            last_bank   = mem_bank;
            last_rd_row = mem_rd_row;
            last_wb_en  = mem_wb_en;
            last_wb_row = mem_wb_row;
            last_wdata  = mem_wdata;
            if (mem_wb_en) store[int'({mem_wb_row, mem_bank})] = mem_wdata;
            pend_bank = mem_bank;
            pend_row  = mem_rd_row;
            mem_cnt   = LAT;
        end else if (mem_cnt == 1) begin
            mem_cnt = 0;
            mem_rvalid <= 1'b1;
            mem_rdata  <= line_of(pend_bank, pend_row);
        end else if (mem_cnt > 1) begin
            mem_cnt--;
        end
    end

    // scoreboard
    logic [63:0] exp_q [$];

    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 response without read", 64'd1, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(resp_rdata == e, "R2/R4 read data", resp_rdata, e);
            end
        end
    end

    task automatic do_req(input bit we, input logic [31:0] a, input logic [63:0] d,
                          input logic [7:0] be, output int stall);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        stall = 0;
        #1;
        while (!req_ready && stall < 500) begin
            @(negedge clk);
            stall++;
        end
        if (!we) exp_q.push_back(exp_word(a));
        @(posedge clk);
        if (we) begin
            logic [63:0] m = exp_word(a);
            for (int b = 0; b < 8; b++) if (be[b]) m[b*8 +: 8] = d[b*8 +: 8];
            ref_mem[int'(a >> 3)] = m;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (we) chk(resp_valid == 1'b0, "R5 write gives no response", 64'(resp_valid), 64'd0);
        else    chk(resp_valid == 1'b1, "R5 read response one cycle after accept", 64'(resp_valid), 64'd1);
    endtask

    task automatic rd(input logic [31:0] a, output int stall);
        do_req(1'b0, a, 64'd0, 8'd0, stall);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R3 run hung actual=0 expected=1");
        finish_run();
    end

    initial begin
        int s, n0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", 64'(resp_valid), 64'd0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", 64'(mem_req), 64'd0);
        @(negedge clk);

        // R1 R3 cold miss
        n0 = req_count;
        rd(mk(1, 2, 5), s);
        chk(req_count - n0 == 1, "R3 one request per miss", 64'(req_count - n0), 64'd1);
        chk(s == LAT + 3, "R1 R3 cold miss stall", 64'(s), 64'(LAT + 3));
        chk(last_bank == 4'd2, "R2 request bank", 64'(last_bank), 64'd2);
        chk(last_rd_row == 19'd1, "R2 request row", 64'(last_rd_row), 64'd1);
        chk(last_wb_en == 1'b0, "R9 no writeback of invalid way", 64'(last_wb_en), 64'd0);

        // R10 same bank right after fill
        rd(mk(2, 2, 7), s);
        chk(gap_same == PRE + 2, "R10 same-bank recovery gap", 64'(gap_same), 64'(PRE + 2));

        // R4 R5 R6 hits in both ways, across the line
        n0 = req_count;
        rd(mk(1, 2, 0), s);
        chk(s == 0, "R5 hit no stall", 64'(s), 64'd0);
        rd(mk(1, 2, 63), s);
        chk(s == 0, "R4 last word hits", 64'(s), 64'd0);
        rd(mk(2, 2, 7), s);
        rd(mk(1, 2, 5), s);
        chk(s == 0, "R6 both tags resident", 64'(s), 64'd0);
        chk(req_count == n0, "R4 no request on hits", 64'(req_count - n0), 64'd0);

        // R10 other bank not delayed
        rd(mk(3, 6, 0), s);
        rd(mk(3, 7, 0), s);
        chk(gap_any == 3, "R10 other bank issues at once", 64'(gap_any), 64'd3);

        // R7 LRU in bank 2: touch tag2 then tag1, tag5 must evict tag2
        rd(mk(2, 2, 1), s);
        rd(mk(1, 2, 1), s);
        rd(mk(5, 2, 0), s);
        chk(last_rd_row == 19'd5, "R7 miss row", 64'(last_rd_row), 64'd5);
        chk(last_wb_en == 1'b0, "R9 clean victim no writeback", 64'(last_wb_en), 64'd0);
        n0 = req_count;
        rd(mk(1, 2, 2), s);
        chk(req_count == n0, "R7 recently used tag kept", 64'(req_count - n0), 64'd0);
        rd(mk(2, 2, 2), s);
        chk(req_count - n0 == 1, "R7 least recent tag evicted", 64'(req_count - n0), 64'd1);

        // R8 byte-enabled writes in bank 7
        n0 = req_count;
        do_req(1'b1, mk(3, 7, 4), 64'h1122_3344_5566_7788, 8'h0F, s);
        chk(s == 0, "R8 write hit no stall", 64'(s), 64'd0);
        rd(mk(3, 7, 4), s);
        do_req(1'b1, mk(3, 7, 5), 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, s);
        rd(mk(3, 7, 5), s);
        chk(req_count == n0, "R8 writes hit without request", 64'(req_count - n0), 64'd0);

        // R9 dirty eviction
        rd(mk(8, 7, 0), s);
        rd(mk(8, 7, 1), s);
        rd(mk(10, 7, 0), s);
        chk(last_wb_en == 1'b1, "R9 dirty victim written back", 64'(last_wb_en), 64'd1);
        chk(last_wb_row == 19'd3, "R9 writeback row", 64'(last_wb_row), 64'd3);
        chk(last_wdata[4*64 +: 64] == exp_word(mk(3, 7, 4)), "R9 writeback data",
            last_wdata[4*64 +: 64], exp_word(mk(3, 7, 4)));
        rd(mk(3, 7, 4), s);
        chk(last_wb_en == 1'b0, "R9 clean victim after reload", 64'(last_wb_en), 64'd0);

        // R8 write miss allocates
        n0 = req_count;
        do_req(1'b1, mk(12, 11, 2), 64'hDEAD_BEEF_0BAD_F00D, 8'hF0, s);
        chk(req_count - n0 == 1, "R8 write miss fills", 64'(req_count - n0), 64'd1);
        rd(mk(12, 11, 2), s);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule